// File: doc/BRIEF.md
# Cascaded Lookup-Table Logic Cell

This cell is one tile of a programmable fabric. Two 4-input lookup tables, called F and G, each compute an arbitrary function of their own four inputs. A small 3-input table, called H, combines the two results with one extra pin. The cell can therefore produce two independent 4-input functions, or one function that draws on all nine inputs. All table contents, multiplexer selects and flip-flop options arrive as static configuration ports. Loading that configuration is the job of logic outside the cell.

Two outputs are combinational. X shows either F' or H'. Y shows either G' or H'. Two registered outputs, XQ and YQ, each capture F', G', H' or a direct data pin. They share a clock enable and a synchronous set/reset, and each flop has a configurable set/reset value. In memory mode the F and G tables become two writable 16x1 RAMs. Each RAM is written at its own table inputs and read asynchronously.

Top module: `clb_lut4`

## Requirements
- R1: In logic mode with `cfg_x_sel`=0, `x_out` equals `cfg_f_tbl[f_in]`, where `f_in[3]` is the most significant index bit.
- R2: In logic mode with `cfg_y_sel`=0, `y_out` equals `cfg_g_tbl[g_in]`, with `g_in[3]` as the most significant bit.
- R3: H' equals `cfg_h_tbl[{h1_in, G', F'}]`, with `h1_in` as the most significant bit. `x_out` shows H' when `cfg_x_sel`=1, and `y_out` shows H' when `cfg_y_sel`=1.
- R4: When `cfg_ram_mode`=1 and `ram_we`=1 at a rising clock edge, the F entry at `f_in` takes `ram_din_f` and the G entry at `g_in` takes `ram_din_g`. Reads are asynchronous, so the new value is visible after that edge.
- R5: When `cfg_ram_mode`=0, `ram_we` has no effect. The tables follow the configuration ports. On entry to memory mode, the RAM contents equal the configuration tables present at the last clock edge in logic mode.
- R6: `xq_out` and `yq_out` capture the source chosen by `cfg_xq_src` and `cfg_yq_src` at a rising edge when `ff_ce`=1 and `ff_sr`=0. The codes are 0=F', 1=G', 2=H', 3=`ff_din`.
- R7: When `ff_ce`=0 and `ff_sr`=0, both flip-flops hold their value across a clock edge.
- R8: When `ff_sr`=1 at a rising edge, `xq_out` loads `cfg_xq_srval` and `yq_out` loads `cfg_yq_srval`, whatever the value of `ff_ce`.
- R9: While `rst_n` is low, `xq_out` and `yq_out` are 0.
- R10: In memory mode with `ram_we`=0, the stored contents persist, and every address reads back its last written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the flip-flops |
| cfg_f_tbl | input | 16 | Truth table for F |
| cfg_g_tbl | input | 16 | Truth table for G |
| cfg_h_tbl | input | 8 | Truth table for H |
| cfg_ram_mode | input | 1 | 1 = F and G act as writable RAMs |
| cfg_x_sel | input | 1 | X source: 0 = F', 1 = H' |
| cfg_y_sel | input | 1 | Y source: 0 = G', 1 = H' |
| cfg_xq_src | input | 2 | XQ data source code |
| cfg_yq_src | input | 2 | YQ data source code |
| cfg_xq_srval | input | 1 | Value XQ takes on set/reset |
| cfg_yq_srval | input | 1 | Value YQ takes on set/reset |
| f_in | input | 4 | F table inputs / RAM address |
| g_in | input | 4 | G table inputs / RAM address |
| h1_in | input | 1 | Direct third input of H |
| ff_din | input | 1 | Direct flip-flop data input |
| ram_we | input | 1 | RAM write enable |
| ram_din_f | input | 1 | Write data for the F RAM |
| ram_din_g | input | 1 | Write data for the G RAM |
| ff_ce | input | 1 | Flip-flop clock enable |
| ff_sr | input | 1 | Synchronous set/reset of both flip-flops |
| x_out | output | 1 | Combinational output X |
| y_out | output | 1 | Combinational output Y |
| xq_out | output | 1 | Registered output XQ |
| yq_out | output | 1 | Registered output YQ |

## Verification
The assertions check four rules on every cycle:
- the logic-mode lookups of F and G against the configuration tables;
- a RAM write becoming visible at the next cycle while the address holds;
- set/reset taking priority over the enable;
- the flops holding when neither control is active.

Only the bench scenarios show the rest:
- the cascaded H function over all its index combinations;
- each flip-flop source code;
- the hand-over of contents when the cell enters memory mode;
- persistence of a whole written RAM image;
- the fact that a write strobe in logic mode leaves everything unchanged.

// File: rtl/clb_lut4.sv
module clb_lut4 #(
  parameter int K = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [(1<<K)-1:0]  cfg_f_tbl,
  input  logic [(1<<K)-1:0]  cfg_g_tbl,
  input  logic [7:0]         cfg_h_tbl,
  input  logic               cfg_ram_mode,
  input  logic               cfg_x_sel,
  input  logic               cfg_y_sel,
  input  logic [1:0]         cfg_xq_src,
  input  logic [1:0]         cfg_yq_src,
  input  logic               cfg_xq_srval,
  input  logic               cfg_yq_srval,
  input  logic [K-1:0]       f_in,
  input  logic [K-1:0]       g_in,
  input  logic               h1_in,
  input  logic               ff_din,
  input  logic               ram_we,
  input  logic               ram_din_f,
  input  logic               ram_din_g,
  input  logic               ff_ce,
  input  logic               ff_sr,
  output logic               x_out,
  output logic               y_out,
  output logic               xq_out,
  output logic               yq_out
);
  localparam int DEPTH = 1 << K;

  logic [DEPTH-1:0] f_mem, g_mem;
  logic f_val, g_val, h_val, xq_d, yq_d;

  // Table storage: mirrors configuration in logic mode, written in memory mode
  always_ff @(posedge clk) begin
    if (!cfg_ram_mode) begin
      f_mem <= cfg_f_tbl;
      g_mem <= cfg_g_tbl;
    end else if (ram_we) begin
      f_mem[f_in] <= ram_din_f;
      g_mem[g_in] <= ram_din_g;
    end
  end

  assign f_val = cfg_ram_mode ? f_mem[f_in] : cfg_f_tbl[f_in];
  assign g_val = cfg_ram_mode ? g_mem[g_in] : cfg_g_tbl[g_in];
  assign h_val = cfg_h_tbl[{h1_in, g_val, f_val}];

  assign x_out = cfg_x_sel ? h_val : f_val;
  assign y_out = cfg_y_sel ? h_val : g_val;

  always_comb begin
    case (cfg_xq_src)
      2'd0:    xq_d = f_val;
      2'd1:    xq_d = g_val;
      2'd2:    xq_d = h_val;
      default: xq_d = ff_din;
    endcase
    case (cfg_yq_src)
      2'd0:    yq_d = f_val;
      2'd1:    yq_d = g_val;
      2'd2:    yq_d = h_val;
      default: yq_d = ff_din;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xq_out <= 1'b0;
      yq_out <= 1'b0;
    end else if (ff_sr) begin
      xq_out <= cfg_xq_srval;
      yq_out <= cfg_yq_srval;
    end else if (ff_ce) begin
      xq_out <= xq_d;
      yq_out <= yq_d;
    end
  end

  p_logic_f_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ram_mode && !cfg_x_sel) |-> (x_out == cfg_f_tbl[f_in]));

  p_logic_g_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ram_mode && !cfg_y_sel) |-> (y_out == cfg_g_tbl[g_in]));

  p_ram_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ram_mode && ram_we) |=>
      (!cfg_ram_mode || !$stable(f_in) || f_val == $past(ram_din_f)));

  p_sr_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ff_sr |=> (xq_out == $past(cfg_xq_srval) && yq_out == $past(cfg_yq_srval)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ff_sr && !ff_ce) |=> ($stable(xq_out) && $stable(yq_out)));

endmodule

// File: tb/clb_lut4_bench.sv
module clb_lut4_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cfg_f_tbl = 16'hA5C3, cfg_g_tbl = 16'h1E78;
  logic [7:0]  cfg_h_tbl = 8'hB4;
  logic cfg_ram_mode = 0, cfg_x_sel = 0, cfg_y_sel = 0;
  logic [1:0] cfg_xq_src = 0, cfg_yq_src = 0;
  logic cfg_xq_srval = 1, cfg_yq_srval = 0;
  logic [3:0] f_in = 0, g_in = 0;
  logic h1_in = 0, ff_din = 0, ram_we = 0, ram_din_f = 0, ram_din_g = 0;
  logic ff_ce = 0, ff_sr = 0;
  logic x_out, y_out, xq_out, yq_out;
  int errors = 0, checks = 0;
  logic [15:0] fm, gm;

  clb_lut4 u_clb_lut4 (.*);

  always #10 clk = ~clk;

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic href(input logic h1, input logic g, input logic f);
    return cfg_h_tbl[{h1, g, f}];
  endfunction

  task automatic t_reset();
    cfg_xq_srval = 1;
    #5;
    chk(xq_out, 1'b0, "R9 xq in reset");
    chk(yq_out, 1'b0, "R9 yq in reset");
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_logic();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      cfg_x_sel = 0; cfg_y_sel = 0;
      f_in = 4'(i); g_in = 4'(15 - i);
      #2;
      chk(x_out, cfg_f_tbl[i], "R1 F lookup");
      chk(y_out, cfg_g_tbl[15 - i], "R2 G lookup");
    end
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      cfg_x_sel = 1; cfg_y_sel = 1;
      f_in = 4'(i * 7); g_in = 4'(i * 3 + 1); h1_in = i[4];
      #2;
      chk(x_out, href(h1_in, cfg_g_tbl[g_in], cfg_f_tbl[f_in]), "R3 H on X");
      chk(y_out, href(h1_in, cfg_g_tbl[g_in], cfg_f_tbl[f_in]), "R3 H on Y");
    end
    cfg_x_sel = 0; cfg_y_sel = 0;
  endtask

  task automatic t_ram();
    @(negedge clk);
    cfg_ram_mode = 1; ram_we = 0;
    fm = cfg_f_tbl; gm = cfg_g_tbl;
    for (int i = 0; i < 16; i += 5) begin
      f_in = 4'(i); g_in = 4'(i);
      #2;
      chk(x_out, fm[i], "R5 F contents on entry");
      chk(y_out, gm[i], "R5 G contents on entry");
      @(negedge clk);
    end
    for (int i = 0; i < 16; i++) begin
      f_in = 4'(i); g_in = 4'(15 - i);
      ram_din_f = i[0] ^ i[2]; ram_din_g = ~i[1];
      ram_we = 1;
      fm[i] = ram_din_f; gm[15 - i] = ram_din_g;
      @(posedge clk); #2;
      chk(x_out, fm[i], "R4 F write visible");
      chk(y_out, gm[15 - i], "R4 G write visible");
      @(negedge clk);
    end
    ram_we = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      ram_din_f = ~fm[i]; ram_din_g = ~gm[i];
      f_in = 4'(i); g_in = 4'(i);
      #2;
      chk(x_out, fm[i], "R10 F persists");
      chk(y_out, gm[i], "R10 G persists");
    end
  endtask

  task automatic t_ignore();
    @(negedge clk);
    cfg_ram_mode = 0;
    for (int i = 0; i < 16; i++) begin
      f_in = 4'(i); g_in = 4'(i);
      ram_we = 1; ram_din_f = ~cfg_f_tbl[i]; ram_din_g = ~cfg_g_tbl[i];
      @(posedge clk); #2;
      chk(x_out, cfg_f_tbl[i], "R5 F write ignored");
      chk(y_out, cfg_g_tbl[i], "R5 G write ignored");
      @(negedge clk);
    end
    ram_we = 0;
    cfg_ram_mode = 1;
    for (int i = 0; i < 16; i++) begin
      f_in = 4'(i); g_in = 4'(i);
      #2;
      chk(x_out, cfg_f_tbl[i], "R5 F reload on entry");
      chk(y_out, cfg_g_tbl[i], "R5 G reload on entry");
      @(negedge clk);
    end
    cfg_ram_mode = 0;
  endtask

  task automatic t_ff();
    logic fv, gv, hv, exp;
    @(negedge clk);
    f_in = 4'd3; g_in = 4'd9; h1_in = 1;
    fv = cfg_f_tbl[3]; gv = cfg_g_tbl[9]; hv = href(1'b1, gv, fv);
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 2; d++) begin
        @(negedge clk);
        cfg_xq_src = 2'(s); cfg_yq_src = 2'(3 - s); ff_din = d[0];
        ff_ce = 1; ff_sr = 0;
        @(posedge clk); #2;
        exp = (s == 0) ? fv : (s == 1) ? gv : (s == 2) ? hv : d[0];
        chk(xq_out, exp, "R6 XQ source");
        exp = (s == 3) ? fv : (s == 2) ? gv : (s == 1) ? hv : d[0];
        chk(yq_out, exp, "R6 YQ source");
      end
    end
    @(negedge clk);
    cfg_xq_src = 3; cfg_yq_src = 3; ff_din = 1;
    @(posedge clk); #2;
    @(negedge clk);
    ff_ce = 0; ff_din = 0;
    @(posedge clk); #2;
    chk(xq_out, 1'b1, "R7 XQ hold");
    chk(yq_out, 1'b1, "R7 YQ hold");
    @(negedge clk);
    ff_sr = 1; ff_ce = 1; ff_din = 0; cfg_xq_srval = 1; cfg_yq_srval = 0;
    @(posedge clk); #2;
    chk(xq_out, 1'b1, "R8 XQ set value");
    chk(yq_out, 1'b0, "R8 YQ reset value");
    @(negedge clk);
    ff_din = 1; cfg_xq_srval = 0; cfg_yq_srval = 1;
    @(posedge clk); #2;
    chk(xq_out, 1'b0, "R8 XQ clear beats enable");
    chk(yq_out, 1'b1, "R8 YQ preset beats enable");
    @(negedge clk);
    ff_sr = 0;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_logic();
    t_ram();
    t_ignore();
    t_ff();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule